// File: doc/BRIEF.md
# Priority Reference Selection Controller

This block decides the operating mode of a timing unit and the input reference it tracks. There are three modes: free run, locked to one of four references, and holdover. The result is a registered 4-bit mode code. A separate monitor supplies one availability flag per reference. Software supplies a 3-bit priority and a revertive flag for each reference, a manual/automatic control bit, a requested mode code and a reversion delay in minutes. The unit also supplies a holdover-history-good flag, a master/slave select and a one-cycle minute tick.

In manual operation the requested code is applied as written. A lock request on an unavailable reference becomes holdover. In automatic operation the controller keeps the current reference while it stays available. When that reference fails, the controller moves to the best available reference. If no reference is available, it falls back to holdover when the history is good and to free run when it is not. A higher-priority reference that returns is taken back only if the current reference is marked revertive, and only after it has stayed available for the programmed number of minute ticks.

When the unit runs as a slave it follows the cross-couple reference. The mode code is then frozen, and requests written meanwhile wait until the unit is master again. Two one-cycle pulses mark changes of the mode code and of the active reference.

Top module: `refsel_ctrl`

## Requirements
- R1: After synchronous reset the mode code is 0000, both pulses and the slave indication are low, control is manual, the requested code is 0000 and the reversion delay is 5.
- R2: The mode code is 0000 for free run, k for locked on reference k (1 to 4), and 1001 for holdover. A manual request of 1001–1111 produces 1001, and a request of 0101–1000 produces 0000.
- R3: In manual master operation a written code appears on the mode code two clock edges after the write strobe is sampled. A lock request on a reference whose availability flag is low produces 1001.
- R4: A code write in automatic master operation is ignored: the mode code does not move, and the stored request is unchanged when manual control is later restored.
- R5: In automatic master operation, if the mode code is not a lock on an available reference, the controller locks on the available reference with the lowest priority value. The priority of reference k+1 sits in bits [3k+2:3k] of the priority bus, and ties go to the lower reference number.
- R6: In automatic master operation with no reference available, the mode code becomes 1001 if the holdover-good flag is high and 0000 if it is low.
- R7: If the current reference is available and its revertive flag is set, and another available reference has a strictly lower priority value, the controller switches to that reference once the delay's number of minute ticks have been counted with the candidate unchanged. A delay of 0 switches two edges after the candidate appears.
- R8: The reversion count restarts from zero if the candidate changes or leaves the available set before the delay is complete.
- R9: If the current reference is available and its revertive flag is clear, the mode code holds even when a higher-priority reference is available.
- R10: While the master input is low, the slave indication is high and the mode code holds. Code writes are still stored, and they take effect once the master input returns high.
- R11: The mode-change pulse is high for exactly the cycles in which the mode code differs from its previous value. The reference-switch pulse is high only on changes where the old or the new code is a lock code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_avail | input | NUM_REFS | Availability flag per reference (bit 0 = reference 1) |
| ref_prio | input | NUM_REFS*PRIO_W | Packed priority per reference, lower value wins |
| ref_revert | input | NUM_REFS | Revertive flag per reference |
| ctrl_wr | input | 1 | Strobe to load the manual/automatic bit |
| ctrl_manual | input | 1 | 1 = manual, 0 = automatic |
| dly_wr | input | 1 | Strobe to load the reversion delay |
| dly_val | input | DLY_W | Reversion delay in minutes |
| code_wr | input | 1 | Strobe to write the requested mode code |
| code_val | input | 4 | Requested mode code |
| hold_good | input | 1 | Holdover history is usable |
| is_master | input | 1 | 1 = master, 0 = slave |
| min_tick | input | 1 | One-cycle pulse per minute |
| mode_code | output | 4 | Registered operating-mode code |
| ref_switch | output | 1 | One-cycle pulse on a change of active reference |
| mode_change | output | 1 | One-cycle pulse on a change of mode code |
| slave_follow | output | 1 | Registered, high while following the cross-couple reference |

## Verification
Directed sequences cover the cases a random run is unlikely to reach. They check equal priorities, to show that a tie resolves toward the lower reference number. They step the tick count to one short of the delay and then to the full delay, which separates a correct counter from an off-by-one. A brief drop of the candidate reference shows whether the count restarts. A zero delay and the default delay are each tried once. Slave and ignored-write episodes check that stored requests survive. A seeded random phase then mixes manual/automatic toggles, code writes, random availability, priorities and holdover flags with revertive flags clear. Each settled mode code is compared against a bench model of the selection rules.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef logic [3:0] mode_t;

  localparam mode_t MODE_FREE = 4'b0000;
  localparam mode_t MODE_HOLD = 4'b1001;

  // A code locks on reference (code) when it lies in 1..nref.
  function automatic logic code_is_locked(mode_t c, int nref);
    return (c != 4'd0) && (int'(c) <= nref);
  endfunction
endpackage

// File: rtl/refsel_pick.sv
module refsel_pick #(
  parameter int NUM_REFS = 4,
  parameter int PRIO_W   = 3,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_REFS-1:0]        avail,
  input  logic [NUM_REFS*PRIO_W-1:0] prio_flat,
  output logic                       best_valid,
  output logic [IDX_W-1:0]           best_idx,
  output logic [PRIO_W-1:0]          best_prio
);
  logic [PRIO_W-1:0] prio_a [NUM_REFS];

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_unpack
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // Strict less-than keeps the lower index on equal priority.
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_prio  = '1;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (avail[i] && (!best_valid || prio_a[i] < best_prio)) begin
        best_valid = 1'b1;
        best_idx   = IDX_W'(i);
        best_prio  = prio_a[i];
      end
    end
  end
endmodule

// File: rtl/refsel_revert_timer.sv
module refsel_revert_timer #(
  parameter int IDX_W = 2,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [IDX_W-1:0] cand,
  input  logic             min_tick,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  logic             armed_q;
  logic [IDX_W-1:0] cand_q;
  logic [DLY_W-1:0] cnt_q;

  assign fire = enable && armed_q && (cand == cand_q) && (cnt_q >= dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cand_q  <= '0;
      cnt_q   <= '0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q || cand != cand_q) begin
      armed_q <= 1'b1;
      cand_q  <= cand;
      cnt_q   <= '0;
    end else if (fire) begin
      cnt_q   <= '0;
    end else if (min_tick && cnt_q < dly) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refsel_cfg.sv
module refsel_cfg #(
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             ctrl_manual,
  input  logic             dly_wr,
  input  logic [DLY_W-1:0] dly_val,
  input  logic             code_wr,
  input  logic [3:0]       code_val,
  input  logic             is_master,
  output logic             manual_q,
  output logic [DLY_W-1:0] dly_q,
  output logic [3:0]       req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      manual_q <= 1'b1;
      dly_q    <= DLY_W'(DLY_RST);
      req_q    <= '0;
    end else begin
      if (ctrl_wr) manual_q <= ctrl_manual;
      if (dly_wr)  dly_q    <= dly_val;
      // Requests are refused only under automatic master control.
      if (code_wr && (manual_q || !is_master)) req_q <= code_val;
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int PRIO_W   = 3,
  parameter int DLY_W    = 8,
  parameter int DLY_RST  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REFS-1:0]        ref_avail,
  input  logic [NUM_REFS*PRIO_W-1:0] ref_prio,
  input  logic [NUM_REFS-1:0]        ref_revert,
  input  logic                       ctrl_wr,
  input  logic                       ctrl_manual,
  input  logic                       dly_wr,
  input  logic [DLY_W-1:0]           dly_val,
  input  logic                       code_wr,
  input  logic [3:0]                 code_val,
  input  logic                       hold_good,
  input  logic                       is_master,
  input  logic                       min_tick,
  output logic [3:0]                 mode_code,
  output logic                       ref_switch,
  output logic                       mode_change,
  output logic                       slave_follow
);
  localparam int IDX_W = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1;

  logic             manual_q;
  logic [DLY_W-1:0] dly_q;
  mode_t            req_q;
  mode_t            mode_q;
  logic             mode_pulse_q, ref_pulse_q, follow_q;

  logic              best_valid;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;

  logic              cur_locked, req_locked, rev_en, rev_fire;
  logic [IDX_W-1:0]  cur_idx, req_idx;
  logic [PRIO_W-1:0] cur_prio;
  mode_t             nxt;

  refsel_cfg #(.DLY_W(DLY_W), .DLY_RST(DLY_RST)) cfg_i (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_manual(ctrl_manual),
    .dly_wr(dly_wr), .dly_val(dly_val),
    .code_wr(code_wr), .code_val(code_val),
    .is_master(is_master),
    .manual_q(manual_q), .dly_q(dly_q), .req_q(req_q)
  );

  refsel_pick #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) pick_i (
    .avail(ref_avail), .prio_flat(ref_prio),
    .best_valid(best_valid), .best_idx(best_idx), .best_prio(best_prio)
  );

  assign cur_locked = code_is_locked(mode_q, NUM_REFS);
  assign cur_idx    = IDX_W'(mode_q - 4'd1);
  assign cur_prio   = ref_prio[cur_idx*PRIO_W +: PRIO_W];
  assign req_locked = code_is_locked(req_q, NUM_REFS);
  assign req_idx    = IDX_W'(req_q - 4'd1);

  assign rev_en = is_master && !manual_q && cur_locked && ref_avail[cur_idx] &&
                  ref_revert[cur_idx] && best_valid && (best_prio < cur_prio);

  refsel_revert_timer #(.IDX_W(IDX_W), .DLY_W(DLY_W)) timer_i (
    .clk(clk), .rst(rst),
    .enable(rev_en), .cand(best_idx), .min_tick(min_tick),
    .dly(dly_q), .fire(rev_fire)
  );

  always_comb begin
    nxt = mode_q;
    if (!is_master) begin
      nxt = mode_q;
    end else if (manual_q) begin
      if (req_q == MODE_FREE)      nxt = MODE_FREE;
      else if (req_locked)         nxt = ref_avail[req_idx] ? req_q : MODE_HOLD;
      else if (req_q >= MODE_HOLD) nxt = MODE_HOLD;
      else                         nxt = MODE_FREE;
    end else if (cur_locked && ref_avail[cur_idx]) begin
      if (rev_fire) nxt = mode_t'(best_idx) + 4'd1;
    end else if (best_valid) begin
      nxt = mode_t'(best_idx) + 4'd1;
    end else begin
      nxt = hold_good ? MODE_HOLD : MODE_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_FREE;
      mode_pulse_q <= 1'b0;
      ref_pulse_q  <= 1'b0;
      follow_q     <= 1'b0;
    end else begin
      mode_q       <= nxt;
      mode_pulse_q <= (nxt != mode_q);
      ref_pulse_q  <= (nxt != mode_q) &&
                      (code_is_locked(nxt, NUM_REFS) || cur_locked);
      follow_q     <= !is_master;
    end
  end

  assign mode_code    = mode_q;
  assign mode_change  = mode_pulse_q;
  assign ref_switch   = ref_pulse_q;
  assign slave_follow = follow_q;
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk
  import refsel_pkg::*;
#(
  parameter int NUM_REFS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_REFS-1:0] ref_avail,
  input logic [NUM_REFS-1:0] ref_revert,
  input logic                is_master,
  input logic                hold_good,
  input logic                manual_q,
  input logic [3:0]          mode_code,
  input logic                ref_switch,
  input logic                mode_change,
  input logic                slave_follow
);
  localparam int IDX_W = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1;

  logic             locked_now;
  logic [IDX_W-1:0] idx_now;
  assign locked_now = code_is_locked(mode_code, NUM_REFS);
  assign idx_now    = IDX_W'(mode_code - 4'd1);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_FREE) || locked_now || (mode_code == MODE_HOLD));

  assert_fallback_R6: assert property (@(posedge clk) disable iff (rst)
    (is_master && !manual_q && ref_avail == '0) |=>
      (mode_code == ($past(hold_good) ? MODE_HOLD : MODE_FREE)));

  assert_nonrevert_R9: assert property (@(posedge clk) disable iff (rst)
    (is_master && !manual_q && locked_now && ref_avail[idx_now] && !ref_revert[idx_now])
      |=> $stable(mode_code));

  assert_slave_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> ($stable(mode_code) && slave_follow));

  assert_mode_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (mode_code != $past(mode_code)) |-> mode_change);

  assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (rst)
    mode_change |-> (mode_code != $past(mode_code)));

  assert_ref_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    ref_switch |-> mode_change);
endmodule

bind refsel_ctrl refsel_ctrl_chk #(.NUM_REFS(NUM_REFS)) chk_i (
  .clk(clk), .rst(rst), .ref_avail(ref_avail), .ref_revert(ref_revert),
  .is_master(is_master), .hold_good(hold_good), .manual_q(manual_q),
  .mode_code(mode_code), .ref_switch(ref_switch), .mode_change(mode_change),
  .slave_follow(slave_follow)
);

// File: tb/refsel_ctrl_tb_top.sv
module refsel_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ref_avail = '0;
  logic [11:0] ref_prio = '0;
  logic [3:0]  ref_revert = '0;
  logic        ctrl_wr = 1'b0, ctrl_manual = 1'b1;
  logic        dly_wr = 1'b0;
  logic [7:0]  dly_val = '0;
  logic        code_wr = 1'b0;
  logic [3:0]  code_val = '0;
  logic        hold_good = 1'b0, is_master = 1'b1, min_tick = 1'b0;
  logic [3:0]  mode_code;
  logic        ref_switch, mode_change, slave_follow;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  refsel_ctrl dut_i (
    .clk(clk), .rst(rst), .ref_avail(ref_avail), .ref_prio(ref_prio),
    .ref_revert(ref_revert), .ctrl_wr(ctrl_wr), .ctrl_manual(ctrl_manual),
    .dly_wr(dly_wr), .dly_val(dly_val), .code_wr(code_wr), .code_val(code_val),
    .hold_good(hold_good), .is_master(is_master), .min_tick(min_tick),
    .mode_code(mode_code), .ref_switch(ref_switch), .mode_change(mode_change),
    .slave_follow(slave_follow)
  );

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_code(logic [3:0] v);
    code_val = v; code_wr = 1'b1; step(1); code_wr = 1'b0;
  endtask

  task automatic set_manual(logic m);
    ctrl_manual = m; ctrl_wr = 1'b1; step(1); ctrl_wr = 1'b0;
  endtask

  task automatic set_dly(logic [7:0] d);
    dly_val = d; dly_wr = 1'b1; step(1); dly_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin min_tick = 1'b1; step(1); min_tick = 1'b0; step(1); end
  endtask

  function automatic logic [11:0] pk(int a, int b, int c, int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic logic [3:0] man_f(logic [3:0] req, logic [3:0] av);
    if (req == 0) return 4'd0;
    if (req <= 4) return av[req-1] ? req : 4'd9;
    if (req >= 9) return 4'd9;
    return 4'd0;
  endfunction

  function automatic logic [3:0] auto_f(logic [3:0] prev, logic [3:0] av,
                                        logic [11:0] pr, logic hg);
    int bi = -1;
    int bp = 8;
    if (prev >= 1 && prev <= 4 && av[prev-1]) return prev;
    for (int k = 0; k < 4; k++)
      if (av[k] && int'(pr[3*k +: 3]) < bp) begin bi = k; bp = int'(pr[3*k +: 3]); end
    if (bi >= 0) return 4'(bi + 1);
    return hg ? 4'd9 : 4'd0;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic       man_m;
    logic [3:0] req_m, expc, mid;
    void'($urandom(32'd4711));
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 mode", int'(mode_code), 0);
    check("R1 pulse", int'(mode_change) + int'(ref_switch), 0);
    check("R1 follow", int'(slave_follow), 0);

    // R3 manual request and R11 pulse timing
    ref_avail = 4'b1111;
    wr_code(4'd2);
    step(1);
    check("R3 manual lock", int'(mode_code), 2);
    check("R11 mode pulse", int'(mode_change), 1);
    check("R11 ref pulse", int'(ref_switch), 1);
    step(1);
    check("R11 pulse width", int'(mode_change) + int'(ref_switch), 0);
    ref_avail = 4'b1011;
    wr_code(4'd3);
    step(2);
    check("R3 unavailable to holdover", int'(mode_code), 9);
    wr_code(4'd12);
    step(2);
    check("R2 high code holdover", int'(mode_code), 9);
    wr_code(4'd6);
    step(1);
    check("R2 unused code free run", int'(mode_code), 0);
    check("R11 ref pulse low on non-lock change", int'(ref_switch), 0);
    check("R11 mode pulse on non-lock change", int'(mode_change), 1);

    // R5 automatic selection with a tie
    ref_prio = pk(2, 5, 2, 7);
    ref_avail = 4'b1111;
    set_manual(1'b0);
    step(3);
    check("R5 tie to lower index", int'(mode_code), 1);
    ref_avail = 4'b1110;
    step(3);
    check("R5 failover", int'(mode_code), 3);
    ref_avail = 4'b1111;
    step(2); ticks(6); step(2);
    check("R9 non-revertive holds", int'(mode_code), 3);
    wr_code(4'd4);
    step(3);
    check("R4 write ignored", int'(mode_code), 3);
    set_manual(1'b1);
    step(3);
    check("R4 stored request unchanged", int'(mode_code), 0);
    set_manual(1'b0);
    step(3);
    check("R5 relock", int'(mode_code), 1);

    // R6 fallback
    hold_good = 1'b1; ref_avail = 4'b0000;
    step(3);
    check("R6 holdover", int'(mode_code), 9);
    hold_good = 1'b0;
    step(3);
    check("R6 free run", int'(mode_code), 0);

    // R7 revertive with the default delay (R1 delay reset value 5)
    ref_prio = pk(0, 5, 2, 7);
    ref_avail = 4'b0100;
    step(3);
    check("R5 single ref", int'(mode_code), 3);
    ref_revert = 4'b1111;
    ref_avail = 4'b0101;
    step(3); ticks(4); step(3);
    check("R7 before delay", int'(mode_code), 3);
    ticks(1); step(3);
    check("R7 R1 after default delay", int'(mode_code), 1);

    // R8 restart
    ref_avail = 4'b0100;
    step(3);
    check("R8 back on ref3", int'(mode_code), 3);
    ref_avail = 4'b0101;
    step(3); ticks(3);
    ref_avail = 4'b0100; step(1); ref_avail = 4'b0101;
    step(2); ticks(3); step(3);
    check("R8 count restarted", int'(mode_code), 3);
    ticks(2); step(3);
    check("R8 switch after full delay", int'(mode_code), 1);

    // R7 zero delay
    set_dly(8'd0);
    ref_avail = 4'b0100;
    step(3);
    check("R7 prep", int'(mode_code), 3);
    ref_avail = 4'b0101;
    step(2);
    check("R7 zero delay", int'(mode_code), 1);

    // R10 slave operation
    is_master = 1'b0;
    step(2);
    check("R10 follow", int'(slave_follow), 1);
    check("R10 frozen", int'(mode_code), 1);
    ref_avail = 4'b0100;
    step(3);
    check("R10 frozen on avail change", int'(mode_code), 1);
    set_manual(1'b1);
    wr_code(4'd4);
    ref_avail = 4'b1111;
    step(2);
    check("R10 write waits", int'(mode_code), 1);
    is_master = 1'b1;
    step(3);
    check("R10 applied as master", int'(mode_code), 4);
    check("R10 follow cleared", int'(slave_follow), 0);

    // Random phase, non-revertive
    ref_revert = 4'b0000;
    man_m = 1'b1; req_m = 4'd4; expc = 4'd4;
    for (int it = 0; it < 300; it++) begin
      int u = $urandom_range(0, 9);
      logic [3:0] v;
      if (u < 2) begin set_manual(!man_m); man_m = !man_m; end
      mid = man_m ? expc : auto_f(expc, ref_avail, ref_prio, hold_good);
      if (u < 5) begin
        v = 4'($urandom_range(0, 15));
        wr_code(v);
        if (man_m) req_m = v;
      end
      ref_avail = 4'($urandom_range(0, 15));
      ref_prio  = 12'($urandom_range(0, 4095));
      hold_good = 1'($urandom_range(0, 1));
      step(3);
      expc = man_m ? man_f(req_m, ref_avail) : auto_f(mid, ref_avail, ref_prio, hold_good);
      check(man_m ? "R3 random manual" : "R5 R6 random auto", int'(mode_code), int'(expc));
    end
    finish_run();
  end
endmodule